// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status and Policy Register

This block is a host-accessible control and interrupt-cause register for an Ethernet MAC. It holds two cause flags: a jabber error, raised when the transmitter runs past its permitted transmit time in 10BASE-T operation, and a system bus error, raised by the bus-master engine. The host clears each flag by writing a one to it. Next to the flags sit their mask and enable bits, a transmit-start mask, and two bits that set the transmit-interrupt policy.

From these bits the block drives a registered, active-high interrupt request. It also drives a one-cycle pulse that tells the rest of the controller when a finished transmission should raise the transmit interrupt flag. A hard reset or a soft reset returns every bit to its reset value. A STOP command clears only the jabber flag. A software-style compatibility code can pin the jabber flag and its mask to zero.

The host port is a plain 32-bit write strobe with data, plus a combinational read-back bus. Bit layout (each bit read/write unless noted): bit 0 jabber flag (write one to clear), bit 1 jabber mask, bit 2 transmit-start mask, bit 3 system-error flag (write one to clear), bit 4 system-error interrupt enable, bit 5 successful-transmit interrupt disable, bit 6 last-descriptor interrupt mode. Bits 31..7 are not implemented.

Top module: `eth_ictl_reg`

## Requirements
- R1: After hard reset (rst_n low), rd_data reads 32'h0000_0006 (jabber mask bit 1 and transmit-start mask bit 2 set, all else zero), and irq and tx_int_set are 0.
- R2: The cause flags (bit 0 jabber, bit 3 system error) clear only when wr_en writes a one to their position. Writing a zero leaves them set, so writing back the value just read clears every pending flag and leaves the control bits unchanged.
- R3: The jabber flag sets on jab_evt only while mode_10bt is 1. With mode_10bt at 0, jab_evt has no effect.
- R4: A cycle with stop_cmd at 1 clears the jabber flag and leaves the system-error flag and bits 1, 2, 4, 5 and 6 unchanged.
- R5: While sw_style equals 8'h01, the jabber flag stays 0 even on jab_evt in 10BASE-T mode, and the jabber mask reads 0 even after the host writes a one to it.
- R6: With bit 6 at 0, a tx_done with tx_ok at 1 pulses tx_int_set unless bit 5 is 1. A tx_done with tx_ok at 0 always pulses it. The pulse appears in the cycle after tx_done and lasts one cycle.
- R7: With bit 6 at 1, a tx_done pulses tx_int_set exactly when tx_desc_last is 1, whatever tx_ok and bit 5 are.
- R8: Any of err_parity, err_mabort or err_tabort sets the system-error flag. No other enable qualifies the parity source.
- R9: irq equals (jabber flag AND NOT jabber mask AND glob_ie) OR (system-error flag AND bit 4), evaluated on the register contents of the same cycle. The system-error term does not depend on glob_ie.
- R10: Writes to bits 31..7 are ignored, and those bits always read 0.
- R11: When a set event and a host write-one-to-clear hit the same flag in the same cycle, the flag ends set.
- R12: A soft_rst cycle sets every bit to its hard-reset value and clears irq and tx_int_set. soft_rst takes priority over writes and events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop_cmd | input | 1 | STOP command, clears the jabber flag |
| sw_style | input | 8 | Software-style code; 8'h01 selects compatibility mode |
| mode_10bt | input | 1 | 10BASE-T mode active |
| glob_ie | input | 1 | Global interrupt enable |
| jab_evt | input | 1 | Transmit time-limit exceeded pulse |
| err_parity | input | 1 | Bus-master data parity error pulse |
| err_mabort | input | 1 | Bus-master master abort pulse |
| err_tabort | input | 1 | Bus-master target abort pulse |
| tx_done | input | 1 | Transmission finished pulse |
| tx_ok | input | 1 | Finished transmission had no error |
| tx_desc_last | input | 1 | Per-descriptor last-interrupt bit of the finished frame |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Register read-back |
| irq | output | 1 | Registered interrupt request |
| tx_int_set | output | 1 | Pulse: raise the transmit interrupt flag |

## Verification
The interrupt request is swept over all 32 combinations of jabber flag, jabber mask, global enable, system-error flag and its enable, with the error source rotated among the three inputs. This shows whether the system-error path truly ignores the global enable and whether the mask gates only the jabber term. The transmit policy is swept over all 16 combinations of the two policy bits, tx_ok and tx_desc_last. This separates the mode where the disable bit governs from the mode where only the descriptor bit counts. Directed sequences set flags and then apply a STOP, a soft reset, the compatibility code, collisions between set and clear, and writes of zero or read-back values. Each of these must show a different, predictable register image.

// File: rtl/eth_ictl_pkg.sv
package eth_ictl_pkg;

  localparam int JAB_FLAG_B = 0;
  localparam int JAB_MASK_B = 1;
  localparam int TXS_MASK_B = 2;
  localparam int SYS_FLAG_B = 3;
  localparam int SYS_EN_B   = 4;
  localparam int TXOK_DIS_B = 5;
  localparam int LAST_EN_B  = 6;
  localparam int USED_W     = 7;

  typedef struct packed {
    logic last_en;
    logic txok_dis;
    logic sys_en;
    logic txs_mask;
    logic jab_mask;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{last_en: 1'b0, txok_dis: 1'b0, sys_en: 1'b0,
                                 txs_mask: 1'b1, jab_mask: 1'b1};

  function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic tx_raise(input logic done, input logic last_en,
                                    input logic txok_dis, input logic ok,
                                    input logic desc_last);
    if (!done)
      return 1'b0;
    if (last_en)
      return desc_last;
    return ~ok | ~txok_dis;
  endfunction

  function automatic logic irq_calc(input logic jab, input logic jab_mask,
                                    input logic gie, input logic sys,
                                    input logic sys_en);
    return (jab & ~jab_mask & gie) | (sys & sys_en);
  endfunction

endpackage

// File: rtl/eth_ictl_causes.sv
module eth_ictl_causes (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic stop_cmd,
  input  logic compat,
  input  logic mode_10bt,
  input  logic jab_evt,
  input  logic err_parity,
  input  logic err_mabort,
  input  logic err_tabort,
  input  logic clr_jab,
  input  logic clr_sys,
  output logic jab_q,
  output logic sys_q,
  output logic jab_d,
  output logic sys_d
);
  import eth_ictl_pkg::*;

  logic jab_set_w;
  logic sys_set_w;

  assign jab_set_w = jab_evt & mode_10bt & ~compat;
  assign sys_set_w = err_parity | err_mabort | err_tabort;

  always_comb begin
    if (soft_rst || stop_cmd || compat)
      jab_d = 1'b0;
    else
      jab_d = w1c_next(jab_q, jab_set_w, clr_jab);
    if (soft_rst)
      sys_d = 1'b0;
    else
      sys_d = w1c_next(sys_q, sys_set_w, clr_sys);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab_q <= 1'b0;
      sys_q <= 1'b0;
    end else begin
      jab_q <= jab_d;
      sys_q <= sys_d;
    end
  end

endmodule

// File: rtl/eth_ictl_ctrl.sv
module eth_ictl_ctrl (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic                 compat,
  input  logic                 wr_en,
  input  eth_ictl_pkg::ctrl_t  wr_ctrl,
  output eth_ictl_pkg::ctrl_t  ctrl_q,
  output eth_ictl_pkg::ctrl_t  ctrl_d
);
  import eth_ictl_pkg::*;

  always_comb begin
    if (soft_rst)
      ctrl_d = CTRL_RST;
    else if (wr_en)
      ctrl_d = wr_ctrl;
    else
      ctrl_d = ctrl_q;
    if (compat && !soft_rst)
      ctrl_d.jab_mask = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= CTRL_RST;
    else
      ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/eth_ictl_txpol.sv
module eth_ictl_txpol (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tx_done,
  input  logic tx_ok,
  input  logic tx_desc_last,
  input  logic last_en,
  input  logic txok_dis,
  output logic tx_int_set
);
  import eth_ictl_pkg::*;

  logic raise_w;

  assign raise_w = tx_raise(tx_done, last_en, txok_dis, tx_ok, tx_desc_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_int_set <= 1'b0;
    else
      tx_int_set <= raise_w & ~soft_rst;
  end

endmodule

// File: rtl/eth_ictl_reg.sv
module eth_ictl_reg #(
  parameter int              REG_W       = 32,
  parameter int              STYLE_W     = 8,
  parameter logic [STYLE_W-1:0] COMPAT_CODE = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               stop_cmd,
  input  logic [STYLE_W-1:0] sw_style,
  input  logic               mode_10bt,
  input  logic               glob_ie,
  input  logic               jab_evt,
  input  logic               err_parity,
  input  logic               err_mabort,
  input  logic               err_tabort,
  input  logic               tx_done,
  input  logic               tx_ok,
  input  logic               tx_desc_last,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq,
  output logic               tx_int_set
);
  import eth_ictl_pkg::*;

  logic  compat_w;
  logic  clr_jab_w;
  logic  clr_sys_w;
  ctrl_t wr_ctrl_w;
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;
  logic  jab_q, sys_q, jab_d, sys_d;
  logic  irq_d;

  assign compat_w  = (sw_style == COMPAT_CODE);
  assign clr_jab_w = wr_en & wr_data[JAB_FLAG_B];
  assign clr_sys_w = wr_en & wr_data[SYS_FLAG_B];

  always_comb begin
    wr_ctrl_w.jab_mask = wr_data[JAB_MASK_B];
    wr_ctrl_w.txs_mask = wr_data[TXS_MASK_B];
    wr_ctrl_w.sys_en   = wr_data[SYS_EN_B];
    wr_ctrl_w.txok_dis = wr_data[TXOK_DIS_B];
    wr_ctrl_w.last_en  = wr_data[LAST_EN_B];
  end

  eth_ictl_causes u_causes (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .stop_cmd   (stop_cmd),
    .compat     (compat_w),
    .mode_10bt  (mode_10bt),
    .jab_evt    (jab_evt),
    .err_parity (err_parity),
    .err_mabort (err_mabort),
    .err_tabort (err_tabort),
    .clr_jab    (clr_jab_w),
    .clr_sys    (clr_sys_w),
    .jab_q      (jab_q),
    .sys_q      (sys_q),
    .jab_d      (jab_d),
    .sys_d      (sys_d)
  );

  eth_ictl_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .compat   (compat_w),
    .wr_en    (wr_en),
    .wr_ctrl  (wr_ctrl_w),
    .ctrl_q   (ctrl_q),
    .ctrl_d   (ctrl_d)
  );

  eth_ictl_txpol u_txpol (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .tx_done      (tx_done),
    .tx_ok        (tx_ok),
    .tx_desc_last (tx_desc_last),
    .last_en      (ctrl_q.last_en),
    .txok_dis     (ctrl_q.txok_dis),
    .tx_int_set   (tx_int_set)
  );

  assign irq_d = irq_calc(jab_d, ctrl_d.jab_mask, glob_ie, sys_d, ctrl_d.sys_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else
      irq <= irq_d;
  end

  always_comb begin
    rd_data             = '0;
    rd_data[JAB_FLAG_B] = jab_q;
    rd_data[JAB_MASK_B] = ctrl_q.jab_mask;
    rd_data[TXS_MASK_B] = ctrl_q.txs_mask;
    rd_data[SYS_FLAG_B] = sys_q;
    rd_data[SYS_EN_B]   = ctrl_q.sys_en;
    rd_data[TXOK_DIS_B] = ctrl_q.txok_dis;
    rd_data[LAST_EN_B]  = ctrl_q.last_en;
  end

endmodule

// File: rtl/eth_ictl_reg_chk.sv
module eth_ictl_reg_chk #(
  parameter int                 REG_W       = 32,
  parameter int                 STYLE_W     = 8,
  parameter logic [STYLE_W-1:0] COMPAT_CODE = 8'h01
) (
  input logic               clk,
  input logic               rst_n,
  input logic               soft_rst,
  input logic               stop_cmd,
  input logic [STYLE_W-1:0] sw_style,
  input logic               mode_10bt,
  input logic               jab_evt,
  input logic               tx_done,
  input logic               tx_desc_last,
  input logic [REG_W-1:0]   rd_data,
  input logic               irq,
  input logic               tx_int_set
);
  import eth_ictl_pkg::*;

  // R3
  jab_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[JAB_FLAG_B]) |-> $past(jab_evt && mode_10bt));

  // R4
  stop_clears_jab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stop_cmd)) |-> !rd_data[JAB_FLAG_B]);

  // R5
  compat_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sw_style) == COMPAT_CODE) |->
      (rd_data[JAB_MASK_B] == 1'b0 && rd_data[JAB_FLAG_B] == 1'b0));

  // R9
  sys_irq_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SYS_FLAG_B] && rd_data[SYS_EN_B]) |-> irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rd_data[SYS_FLAG_B] && rd_data[SYS_EN_B]) ||
             (rd_data[JAB_FLAG_B] && !rd_data[JAB_MASK_B])));

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:USED_W] == '0);

  // R7
  last_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(soft_rst) && $past(tx_done) && $past(rd_data[LAST_EN_B]))
      |-> (tx_int_set == $past(tx_desc_last)));

  // R12
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(soft_rst)) |->
      (rd_data == REG_W'(6) && !irq && !tx_int_set));

endmodule

bind eth_ictl_reg eth_ictl_reg_chk #(
  .REG_W(REG_W), .STYLE_W(STYLE_W), .COMPAT_CODE(COMPAT_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .stop_cmd     (stop_cmd),
  .sw_style     (sw_style),
  .mode_10bt    (mode_10bt),
  .jab_evt      (jab_evt),
  .tx_done      (tx_done),
  .tx_desc_last (tx_desc_last),
  .rd_data      (rd_data),
  .irq          (irq),
  .tx_int_set   (tx_int_set)
);

// File: tb/tb_eth_ictl_reg.sv
`timescale 1ns/1ps
module tb_eth_ictl_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        stop_cmd = 1'b0;
  logic [7:0]  sw_style = 8'h00;
  logic        mode_10bt = 1'b0;
  logic        glob_ie = 1'b0;
  logic        jab_evt = 1'b0;
  logic        err_parity = 1'b0;
  logic        err_mabort = 1'b0;
  logic        err_tabort = 1'b0;
  logic        tx_done = 1'b0;
  logic        tx_ok = 1'b0;
  logic        tx_desc_last = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        tx_int_set;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  eth_ictl_reg dut (.*);

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic exp_tx(input logic last_en, input logic dis,
                                  input logic ok, input logic dl);
    if (last_en) return dl;
    return !(ok && dis);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset image
    chk("R1 rd", rd_data, 32'h6);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 txint", {31'b0, tx_int_set}, 32'h0);

    // R10 reserved and unused bits ignored
    wr(32'hFFFF_0006);
    chk("R10 upper", rd_data, 32'h6);
    wr(32'hFFFF_FF86);
    chk("R10 unused", rd_data, 32'h6);

    // R3 jabber gated by 10BASE-T mode
    mode_10bt = 1'b0; jab_evt = 1'b1; step(); jab_evt = 1'b0;
    chk("R3 no-mode", rd_data, 32'h6);
    mode_10bt = 1'b1; jab_evt = 1'b1; step(); jab_evt = 1'b0;
    chk("R3 mode", rd_data, 32'h7);

    // R2 write-zero keeps, write-one clears
    wr(32'h6);
    chk("R2 w0", rd_data, 32'h7);
    wr(32'h7);
    chk("R2 w1", rd_data, 32'h6);

    // R9 / R8 sweep
    for (int i = 0; i < 32; i++) begin
      logic j, m, g, s, e;
      j = i[0]; m = i[1]; g = i[2]; s = i[3]; e = i[4];
      wr({27'b0, e, 1'b1, 1'b1, m, 1'b1});
      jab_evt = j; glob_ie = g;
      err_parity = s && (i % 3 == 0);
      err_mabort = s && (i % 3 == 1);
      err_tabort = s && (i % 3 == 2);
      step();
      jab_evt = 1'b0; err_parity = 1'b0; err_mabort = 1'b0; err_tabort = 1'b0;
      // R9
      chk("R9 irq", {31'b0, irq}, {31'b0, (j & ~m & g) | (s & e)});
      // R8
      chk("R8 sysflag", {31'b0, rd_data[3]}, {31'b0, s});
    end
    glob_ie = 1'b0;

    // R4 STOP
    wr(32'h7F);
    jab_evt = 1'b1; err_tabort = 1'b1; step(); jab_evt = 1'b0; err_tabort = 1'b0;
    chk("R4 pre", rd_data, 32'h7F);
    stop_cmd = 1'b1; step(); stop_cmd = 1'b0;
    chk("R4 stop", rd_data, 32'h7E);

    // R11 collision: set wins
    wr(32'h09);
    chk("R11 clr", rd_data, 32'h0);
    jab_evt = 1'b1; err_mabort = 1'b1;
    wr_en = 1'b1; wr_data = 32'h09;
    step();
    wr_en = 1'b0; wr_data = '0; jab_evt = 1'b0; err_mabort = 1'b0;
    chk("R11 both", rd_data, 32'h9);

    // R2 read and write back clears flags only
    wr(32'h39);
    jab_evt = 1'b1; err_parity = 1'b1; step(); jab_evt = 1'b0; err_parity = 1'b0;
    chk("R2 set", rd_data, 32'h39);
    wr(rd_data);
    chk("R2 writeback", rd_data, 32'h30);

    // R5 compatibility style
    wr(32'h06);
    sw_style = 8'h01; step();
    chk("R5 mask", rd_data, 32'h4);
    jab_evt = 1'b1; step(); jab_evt = 1'b0;
    chk("R5 noset", rd_data, 32'h4);
    wr(32'h06);
    chk("R5 wrmask", rd_data, 32'h4);
    sw_style = 8'h02;
    wr(32'h06);
    chk("R5 leave", rd_data, 32'h6);
    sw_style = 8'h00;

    // R6 / R7 transmit policy sweep
    for (int i = 0; i < 16; i++) begin
      logic le, dis, ok, dl;
      le = i[3]; dis = i[2]; ok = i[1]; dl = i[0];
      wr({25'b0, le, dis, 5'b00110});
      tx_done = 1'b1; tx_ok = ok; tx_desc_last = dl;
      step();
      tx_done = 1'b0; tx_ok = 1'b0; tx_desc_last = 1'b0;
      if (le) chk("R7 tx", {31'b0, tx_int_set}, {31'b0, exp_tx(le, dis, ok, dl)});
      else    chk("R6 tx", {31'b0, tx_int_set}, {31'b0, exp_tx(le, dis, ok, dl)});
      step();
      chk("R6 pulse", {31'b0, tx_int_set}, 32'h0);
    end

    // R12 soft reset
    wr(32'h79);
    jab_evt = 1'b1; err_parity = 1'b1; glob_ie = 1'b1; step();
    jab_evt = 1'b0; err_parity = 1'b0;
    chk("R12 pre", {31'b0, irq}, 32'h1);
    soft_rst = 1'b1; wr_en = 1'b1; wr_data = 32'h7F; tx_done = 1'b1;
    step();
    soft_rst = 1'b0; wr_en = 1'b0; wr_data = '0; tx_done = 1'b0;
    chk("R12 rd", rd_data, 32'h6);
    chk("R12 irq", {30'b0, irq, tx_int_set}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule